// File: doc/BRIEF.md
# Shared Memory Bus Ownership Arbiter

This block decides who may drive a shared memory bus: a processor or one of several devices that move data on their own. Each device holds its own request line high. It places data on the bus, and then pulses its data strobe, only after its acknowledge has come back. The processor must hold a grant before it starts a transfer. Only the grant and acknowledge lines and a one-hot owner vector leave the block. Data transfer, address generation and pad drivers sit elsewhere.

When the bus is idle, the lowest-numbered requesting device wins. Any device wins over the processor. The owner keeps the bus until it drops its own request, and nobody can pre-empt it. The bus then stays free for exactly one cycle before the next grant is made. The processor gives up waiting after `TIMEOUT_CYCLES` consecutive cycles without a grant. At that point the block pulses a timeout flag, and the processor is ignored until its request falls and rises again. An error output goes high whenever more than one grant or acknowledge is active at the same time.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While reset is asserted, every acknowledge, the processor grant, the owner vector, the timeout flag and the error flag are low.
- R2: At most one of `dev_ack` and `cpu_grant` is high in any cycle, and `overlap_err` stays low.
- R3: On an idle bus with several device requests sampled at a clock edge, the device with the lowest index is acknowledged, starting right after that edge.
- R4: On an idle bus, a device request beats a simultaneous processor request.
- R5: The owner keeps its acknowledge or grant for as long as its request stays high, even when a higher-priority request arrives.
- R6: When the owner's request is sampled low, its acknowledge or grant falls after that edge. No owner exists for one cycle, and the next grant follows the next edge.
- R7: If `cpu_req` is high at `TIMEOUT_CYCLES` consecutive edges without a grant being given, `cpu_timeout` is high for exactly the one cycle after the last of those edges.
- R8: After a timeout, the processor is not granted while `cpu_req` stays high, even on an idle bus. Once `cpu_req` drops for a cycle and rises again, it can be granted.
- R9: `owner_onehot` bit i (for i below the device count) equals `dev_ack[i]`, and its top bit equals `cpu_grant`.
- R10: An acknowledge or grant only rises after an edge at which that requester's request was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | NDEV | Device bus requests, bit 0 has the highest priority |
| dev_ack | output | NDEV | Device acknowledges, at most one high |
| cpu_req | input | 1 | Processor bus request |
| cpu_grant | output | 1 | Processor bus grant |
| cpu_timeout | output | 1 | One-cycle pulse when the processor gives up waiting |
| owner_onehot | output | NDEV+1 | Current owner, top bit is the processor |
| overlap_err | output | 1 | High if more than one owner is active |

## Verification
A corrupted owner register appears on the acknowledge and grant lines in the same cycle as the fault. It shows up as a second active owner, which also raises `overlap_err`, or as an owner whose request is low. A wrong priority or a missing release gap shows one cycle after the deciding edge. A stuck or miscounted wait counter moves the timeout pulse away from its cycle, and only after a full `TIMEOUT_CYCLES` window. The bench therefore checks the exact cycle of that pulse, as well as the cycles just before and after it.

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter #(
  parameter int          NDEV           = 4,
  parameter logic [15:0] TIMEOUT_CYCLES = 16'd24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_req,
  output logic [NDEV-1:0] dev_ack,
  input  logic            cpu_req,
  output logic            cpu_grant,
  output logic            cpu_timeout,
  output logic [NDEV:0]   owner_onehot,
  output logic            overlap_err
);
  localparam int OW = NDEV + 1;
  localparam logic [OW-1:0] ONE = OW'(1);

  logic [OW-1:0] owner_q, owner_d, cand, pick;
  logic [15:0]   wait_q;
  logic          gave_up_q, busy, holder_keeps, cpu_waiting;

  assign cand         = {cpu_req & ~gave_up_q, dev_req};
  assign pick         = cand & (~cand + ONE);
  assign busy         = |owner_q;
  assign holder_keeps = |(owner_q & {cpu_req, dev_req});

  always_comb begin
    if (busy) owner_d = holder_keeps ? owner_q : '0;
    else      owner_d = pick;
  end

  assign cpu_waiting = cpu_req & ~gave_up_q & ~owner_d[NDEV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q     <= '0;
      wait_q      <= '0;
      gave_up_q   <= 1'b0;
      cpu_timeout <= 1'b0;
    end else begin
      owner_q     <= owner_d;
      cpu_timeout <= 1'b0;
      if (!cpu_req) begin
        wait_q    <= '0;
        gave_up_q <= 1'b0;
      end else if (cpu_waiting) begin
        if (wait_q == TIMEOUT_CYCLES - 16'd1) begin
          wait_q      <= '0;
          gave_up_q   <= 1'b1;
          cpu_timeout <= 1'b1;
        end else begin
          wait_q <= wait_q + 16'd1;
        end
      end else begin
        wait_q <= '0;
      end
    end
  end

  assign dev_ack      = owner_q[NDEV-1:0];
  assign cpu_grant    = owner_q[NDEV];
  assign owner_onehot = owner_q;
  assign overlap_err  = |(owner_q & (owner_q - ONE));

  assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_grant, dev_ack}));

  assert_no_overlap_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !overlap_err);

  assert_timeout_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_timeout |=> !cpu_timeout);

  assert_timeout_not_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_timeout |-> !cpu_grant);

  assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !holder_keeps) |=> !busy);

  assert_cpu_grant_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_grant) |-> $past(cpu_req));

  assert_cpu_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && cpu_req) |=> cpu_grant);

  for (genvar i = 0; i < NDEV; i++) begin : g_dev_chk
    assert_ack_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_ack[i]) |-> $past(dev_req[i]));
    assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack[i] && dev_req[i]) |=> dev_ack[i]);
  end
endmodule

// File: tb/bus_owner_arbiter_test.sv
`timescale 1ns/1ps
module bus_owner_arbiter_test;
  localparam int          NDEV = 4;
  localparam logic [15:0] LIMIT = 16'd24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NDEV-1:0] dev_req = '0;
  logic            cpu_req = 1'b0;
  logic [NDEV-1:0] dev_ack;
  logic            cpu_grant, cpu_timeout, overlap_err;
  logic [NDEV:0]   owner_onehot;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bus_owner_arbiter #(.NDEV(NDEV), .TIMEOUT_CYCLES(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_ack(dev_ack),
    .cpu_req(cpu_req), .cpu_grant(cpu_grant), .cpu_timeout(cpu_timeout),
    .owner_onehot(owner_onehot), .overlap_err(overlap_err));

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {dev_req, cpu_req, expected dev_ack, expected cpu_grant}
  localparam logic [9:0] VEC [13] = '{
    10'b0000_0_0000_0,  // idle
    10'b1010_0_0010_0,  // R3 dev1 beats dev3
    10'b1011_0_0010_0,  // R5 dev0 cannot pre-empt
    10'b1001_0_0000_0,  // R6 release, gap
    10'b1001_0_0001_0,  // R3 dev0 next
    10'b1000_1_0000_0,  // R6 release
    10'b1000_1_1000_0,  // R4 device beats cpu
    10'b0000_1_0000_0,  // R6 release
    10'b0000_1_0000_1,  // cpu granted
    10'b0001_1_0000_1,  // R5 cpu held
    10'b0001_0_0000_0,  // R6 cpu release
    10'b0001_0_0001_0,  // dev0
    10'b0000_0_0000_0   // idle
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ack in reset", 32'(dev_ack), 0);
    check("R1 grant in reset", 32'(cpu_grant), 0);
    check("R1 owner in reset", 32'(owner_onehot), 0);
    check("R1 timeout in reset", 32'(cpu_timeout), 0);
    check("R1 err in reset", 32'(overlap_err), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 13; k++) begin
      dev_req = VEC[k][9:6];
      cpu_req = VEC[k][5];
      step();
      check($sformatf("R3 R4 R5 R6 ack step %0d", k), 32'(dev_ack), 32'(VEC[k][4:1]));
      check($sformatf("R4 R5 R6 grant step %0d", k), 32'(cpu_grant), 32'(VEC[k][0]));
      check($sformatf("R9 owner step %0d", k), 32'(owner_onehot), 32'({VEC[k][0], VEC[k][4:1]}));
      check($sformatf("R2 err step %0d", k), 32'(overlap_err), 0);
      check($sformatf("R7 no timeout step %0d", k), 32'(cpu_timeout), 0);
    end

    // R10: no ack without request
    dev_req = '0; cpu_req = 1'b0;
    step();
    check("R10 idle no ack", 32'(owner_onehot), 0);

    // R7 timeout window while device 2 owns the bus
    dev_req = 4'b0100;
    step();
    check("R3 dev2 ack", 32'(dev_ack), 32'h4);
    cpu_req = 1'b1;
    for (int c = 1; c < int'(LIMIT); c++) begin
      step();
      if (cpu_timeout !== 1'b0) check($sformatf("R7 early timeout cycle %0d", c), 32'(cpu_timeout), 0);
    end
    check("R7 no early timeout", 32'(cpu_timeout), 0);
    step();
    check("R7 timeout pulse", 32'(cpu_timeout), 1);
    check("R8 no grant at timeout", 32'(cpu_grant), 0);
    step();
    check("R7 pulse one cycle", 32'(cpu_timeout), 0);

    // R8 abandoned cpu stays ungranted on an idle bus
    dev_req = '0;
    step();
    check("R6 dev2 released", 32'(dev_ack), 0);
    step();
    check("R8 abandoned no grant", 32'(cpu_grant), 0);
    step();
    check("R8 abandoned still no grant", 32'(cpu_grant), 0);
    check("R8 no repeat timeout", 32'(cpu_timeout), 0);
    cpu_req = 1'b0;
    step();
    check("R8 still idle after drop", 32'(owner_onehot), 0);
    cpu_req = 1'b1;
    step();
    check("R8 retry granted", 32'(cpu_grant), 1);
    check("R9 owner cpu", 32'(owner_onehot), 32'h10);

    // R1 reset in mid-ownership
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears grant", 32'(cpu_grant), 0);
    check("R1 async reset clears owner", 32'(owner_onehot), 0);
    step();
    cpu_req = 1'b0;
    rst_n = 1'b1;
    step();
    check("R1 idle after reset", 32'(owner_onehot), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule